// File: doc/BRIEF.md
# Debug Register Scan Chain

This block sits behind a test access port's data-register path and lets a debugger reach a bank of 32-bit registers addressed by 7 bits. The access port's controller drives three one-clock strobes: capture, shift and update. It also drives one serial input and takes one serial output. The controller itself is not part of this block. Every scan moves a 40-bit frame through the chain. The frame holds a data word, a register address and a direction flag.

On the update strobe, a completed frame becomes one register-bank access. A write stores the data word at the address. A read fetches the addressed register, and that value comes back in the data field of the next scan. Some registers change state when they are read, such as a trace memory data port that advances its read pointer. To finish a read sequence without consuming an extra entry, a debugger ends it with a read of a register that has no side effect. The bank side uses a plain synchronous port, and read data returns one clock after the read strobe.

Top module: `dbg_reg_scan`

## Requirements
- R1: The frame layout is fixed. Chain bits 0 to 31 carry data, bits 32 to 38 carry the register address, and bit 39 carries the direction flag. Each shift strobe moves the chain one place toward bit 0. `sdi` enters at bit 39 and `sdo` always shows bit 0, so data bit 0 leaves first and the flag leaves last.
- R2: A capture strobe loads the data field with the value held from the most recent read. It loads zero into the address and flag fields and restarts the shift count.
- R3: A flag of 1 means write. An accepted write frame raises `bank_we` for exactly one clock, in the cycle after the update strobe, with the frame's address on `bank_addr` and its data on `bank_wdata`. `bank_re` stays low.
- R4: A flag of 0 means read. An accepted read frame raises `bank_re` for exactly one clock, in the cycle after the update strobe, with the frame's address. The value on `bank_rdata` one clock later is held, and the next scan shifts it out in its data field.
- R5: An update leads to a bank access only when exactly 40 shift strobes came between the last capture and that update. With 39 or 41 shifts there is no strobe on the bank, and the held read value does not change.
- R6: A second update strobe that follows without a new capture causes no further bank access.
- R7: After reset, `sdo`, `bank_we` and `bank_re` are 0, and the held read value is 0.
- R8: A write frame leaves the held read value unchanged, so the scan after a write returns the result of the last read before it.
- R9: Every accepted read of a side-effect register (address 0x4) causes exactly one read strobe. A sequence that ends with a read of address 0x0 therefore advances that register only once per intended read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| capture_en | input | 1 | Capture strobe from the access port controller |
| shift_en | input | 1 | Shift strobe, one bit per clock |
| update_en | input | 1 | Update strobe that commits the frame |
| sdi | input | 1 | Serial data into chain bit 39 |
| sdo | output | 1 | Serial data out, chain bit 0 |
| bank_addr | output | 7 | Register address of the access |
| bank_wdata | output | 32 | Write data |
| bank_we | output | 1 | One-clock write strobe |
| bank_re | output | 1 | One-clock read strobe |
| bank_rdata | input | 32 | Read data, valid one clock after `bank_re` |

## Verification
The embedded assertions check the following on every cycle:
- the header fields are zero after each capture;
- each shift moves the chain by exactly one place;
- each bank strobe lasts one clock and the two strobes never overlap;
- every strobe is preceded by an update;
- the held read value changes only two clocks after a read strobe.

Only the bench scenarios can show the end-to-end behaviour:
- the read pipeline returns data one scan late;
- writes leave the held value alone;
- 39-shift and 41-shift frames are rejected;
- a repeated update is ignored;
- the side-effect register is popped exactly once per intended read.

// File: rtl/dbg_reg_scan_pkg.sv
package dbg_reg_scan_pkg;
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_READ  = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/dbg_reg_scan_chain.sv
module dbg_reg_scan_chain #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 7
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            capture_en,
  input  logic                            shift_en,
  input  logic                            update_en,
  input  logic                            sdi,
  input  logic [DATA_W-1:0]               load_data,
  output logic                            sdo,
  output logic [DATA_W+ADDR_W:0]          frame,
  output logic                            frame_ok
);
  localparam int CHAIN_W = DATA_W + ADDR_W + 1;
  localparam int CNT_W   = $clog2(CHAIN_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(CHAIN_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(CHAIN_W + 1);

  logic [CHAIN_W-1:0] sr;
  logic [CNT_W-1:0]   cnt;
  logic               armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr    <= '0;
      cnt   <= '0;
      armed <= 1'b0;
    end else if (capture_en) begin
      sr    <= {{(ADDR_W + 1){1'b0}}, load_data};
      cnt   <= '0;
      armed <= 1'b1;
    end else if (shift_en) begin
      sr    <= {sdi, sr[CHAIN_W-1:1]};
      if (cnt != CNT_OVER) cnt <= cnt + 1'b1;
    end else if (update_en) begin
      armed <= 1'b0;
    end
  end

  assign sdo      = sr[0];
  assign frame    = sr;
  assign frame_ok = update_en && !capture_en && !shift_en && armed && (cnt == CNT_FULL);

  a_r2_capture_clears_header: assert property (@(posedge clk) disable iff (rst)
    capture_en |=> (sr[CHAIN_W-1:DATA_W] == '0) && (cnt == '0));

  a_r1_shift_one_place: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !capture_en) |=> (sr[CHAIN_W-2:0] == $past(sr[CHAIN_W-1:1])));

  a_r6_update_disarms: assert property (@(posedge clk) disable iff (rst)
    (update_en && !capture_en && !shift_en) |=> !frame_ok);
endmodule

// File: rtl/dbg_reg_scan_access.sv
module dbg_reg_scan_access
  import dbg_reg_scan_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 7
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   frame_ok,
  input  logic [DATA_W+ADDR_W:0] frame,
  input  logic [DATA_W-1:0]      bank_rdata,
  output logic [ADDR_W-1:0]      bank_addr,
  output logic [DATA_W-1:0]      bank_wdata,
  output logic                   bank_we,
  output logic                   bank_re,
  output logic [DATA_W-1:0]      hold
);
  localparam int FLAG_BIT = DATA_W + ADDR_W;

  acc_kind_e   kind;
  logic        re_d;

  always_comb begin
    if (!frame_ok)          kind = ACC_NONE;
    else if (frame[FLAG_BIT]) kind = ACC_WRITE;
    else                    kind = ACC_READ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_addr  <= '0;
      bank_wdata <= '0;
      bank_we    <= 1'b0;
      bank_re    <= 1'b0;
      re_d       <= 1'b0;
      hold       <= '0;
    end else begin
      bank_we <= 1'b0;
      bank_re <= 1'b0;
      re_d    <= bank_re;
      if (kind != ACC_NONE) bank_addr <= frame[FLAG_BIT-1:DATA_W];
      if (kind == ACC_WRITE) begin
        bank_we    <= 1'b1;
        bank_wdata <= frame[DATA_W-1:0];
      end
      if (kind == ACC_READ) bank_re <= 1'b1;
      if (re_d) hold <= bank_rdata;
    end
  end

  a_r3_we_one_clock: assert property (@(posedge clk) disable iff (rst)
    bank_we |=> !bank_we);

  a_r4_re_one_clock: assert property (@(posedge clk) disable iff (rst)
    bank_re |=> !bank_re);

  a_r3_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(bank_we && bank_re));

  a_r8_hold_only_after_read: assert property (@(posedge clk) disable iff (rst)
    !$stable(hold) |-> $past(bank_re, 2));
endmodule

// File: rtl/dbg_reg_scan.sv
module dbg_reg_scan #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture_en,
  input  logic              shift_en,
  input  logic              update_en,
  input  logic              sdi,
  output logic              sdo,
  output logic [ADDR_W-1:0] bank_addr,
  output logic [DATA_W-1:0] bank_wdata,
  output logic              bank_we,
  output logic              bank_re,
  input  logic [DATA_W-1:0] bank_rdata
);
  localparam int CHAIN_W = DATA_W + ADDR_W + 1;

  logic [CHAIN_W-1:0] frame;
  logic               frame_ok;
  logic [DATA_W-1:0]  hold;

  dbg_reg_scan_chain #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chain (
    .clk(clk), .rst(rst),
    .capture_en(capture_en), .shift_en(shift_en), .update_en(update_en),
    .sdi(sdi), .load_data(hold), .sdo(sdo),
    .frame(frame), .frame_ok(frame_ok)
  );

  dbg_reg_scan_access #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_access (
    .clk(clk), .rst(rst),
    .frame_ok(frame_ok), .frame(frame), .bank_rdata(bank_rdata),
    .bank_addr(bank_addr), .bank_wdata(bank_wdata),
    .bank_we(bank_we), .bank_re(bank_re), .hold(hold)
  );

  a_r5_access_needs_update: assert property (@(posedge clk) disable iff (rst)
    (bank_we || bank_re) |-> $past(update_en));
endmodule

// File: tb/dbg_reg_scan_bench.sv
module dbg_reg_scan_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic capture_en = 1'b0, shift_en = 1'b0, update_en = 1'b0, sdi = 1'b0;
  logic sdo, bank_we, bank_re;
  logic [6:0]  bank_addr;
  logic [31:0] bank_wdata;
  logic [31:0] bank_rdata;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dbg_reg_scan u_dbg_reg_scan (
    .clk(clk), .rst(rst), .capture_en(capture_en), .shift_en(shift_en),
    .update_en(update_en), .sdi(sdi), .sdo(sdo), .bank_addr(bank_addr),
    .bank_wdata(bank_wdata), .bank_we(bank_we), .bank_re(bank_re),
    .bank_rdata(bank_rdata)
  );

  // bank model: address 0x4 is a side-effect register that pops on read
  logic [31:0] mem [128];
  int pop_cnt = 0;
  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 32'h0;
    bank_rdata = 32'h0;
  end
  always @(posedge clk) begin
    if (bank_we) mem[bank_addr] <= bank_wdata;
    if (bank_re) begin
      if (bank_addr == 7'h4) begin
        bank_rdata <= 32'hF1F0_0000 + pop_cnt;
        pop_cnt <= pop_cnt + 1;
      end else bank_rdata <= mem[bank_addr];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // scan results
  logic [31:0] out_data;
  logic [7:0]  out_hdr;
  int          n_we, n_re;
  logic [6:0]  seen_addr;
  logic [31:0] seen_wdata;

  task automatic scan(input bit wr, input logic [6:0] a, input logic [31:0] d,
                      input int nshift, input bit dbl_upd);
    logic [39:0] v;
    logic [39:0] rec;
    v = {wr, a, d};
    rec = '0;
    n_we = 0; n_re = 0;
    @(negedge clk) capture_en = 1'b1;
    @(negedge clk) capture_en = 1'b0;
    for (int i = 0; i < nshift; i++) begin
      if (i < 40) rec[i] = sdo;
      shift_en = 1'b1;
      sdi = (i < 40) ? v[i] : 1'b0;
      @(negedge clk);
    end
    shift_en = 1'b0;
    update_en = 1'b1;
    @(negedge clk) update_en = 1'b0;
    for (int k = 0; k < 4; k++) begin
      if (bank_we) begin n_we++; seen_addr = bank_addr; seen_wdata = bank_wdata; end
      if (bank_re) begin n_re++; seen_addr = bank_addr; end
      if (dbl_upd && k == 0) update_en = 1'b1;
      @(negedge clk);
      update_en = 1'b0;
    end
    for (int k = 0; k < 3; k++) begin
      if (bank_we) n_we++;
      if (bank_re) n_re++;
      @(negedge clk);
    end
    out_data = rec[31:0];
    out_hdr  = rec[39:32];
  endtask

  // {write flag, address, data, expected data returned in this scan}
  localparam logic [71:0] TBL [7] = '{
    {1'b1, 7'h10, 32'hA5A5_0001, 32'h0000_0000},
    {1'b1, 7'h7F, 32'hDEAD_BEEF, 32'h0000_0000},
    {1'b0, 7'h10, 32'h0000_0000, 32'h0000_0000},
    {1'b0, 7'h7F, 32'h0000_0000, 32'hA5A5_0001},
    {1'b1, 7'h22, 32'h0123_4567, 32'hDEAD_BEEF},
    {1'b0, 7'h22, 32'h0000_0000, 32'hDEAD_BEEF},
    {1'b0, 7'h00, 32'h0000_0000, 32'h0123_4567}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R7: reset state
    chk(sdo == 1'b0, "R7 sdo", {31'b0, sdo}, 32'h0);
    chk(!bank_we && !bank_re, "R7 strobes", {30'b0, bank_we, bank_re}, 32'h0);
    rst = 1'b0;
    @(negedge clk);

    for (int t = 0; t < 7; t++) begin
      logic        wr;
      logic [6:0]  a;
      logic [31:0] d, e;
      {wr, a, d, e} = TBL[t];
      scan(wr, a, d, 40, 1'b0);
      // R1 R2 R4 R8: returned data is the previous read result
      chk(out_data == e, "R4/R8 returned data", out_data, e);
      chk(out_hdr == 8'h0, "R2 header zero", {24'b0, out_hdr}, 32'h0);
      if (wr) begin
        chk(n_we == 1 && n_re == 0, "R3 one write strobe", n_we, 1);
        chk(seen_addr == a && seen_wdata == d, "R1 R3 write addr/data", seen_wdata, d);
      end else begin
        chk(n_re == 1 && n_we == 0, "R4 one read strobe", n_re, 1);
        chk(seen_addr == a, "R1 R4 read addr", {25'b0, seen_addr}, {25'b0, a});
      end
    end

    // R5: 39 shifts -> no access
    scan(1'b1, 7'h30, 32'h1111_2222, 39, 1'b0);
    chk(n_we == 0 && n_re == 0, "R5 short frame ignored", n_we + n_re, 0);
    chk(mem[7'h30] == 32'h0, "R5 short frame no store", mem[7'h30], 32'h0);
    // R5: 41 shifts -> no access
    scan(1'b1, 7'h31, 32'h3333_4444, 41, 1'b0);
    chk(n_we == 0 && n_re == 0, "R5 long frame ignored", n_we + n_re, 0);
    // R5: a rejected read frame leaves hold alone (last read was 0x00 -> 0)
    scan(1'b0, 7'h7F, 32'h0, 39, 1'b0);
    chk(n_re == 0, "R5 short read ignored", n_re, 0);
    scan(1'b0, 7'h10, 32'h0, 40, 1'b0);
    chk(out_data == 32'h0, "R5 hold unchanged after rejected read", out_data, 32'h0);

    // R6: double update gives one access only
    scan(1'b1, 7'h40, 32'h5555_6666, 40, 1'b1);
    chk(n_we == 1, "R6 repeated update ignored", n_we, 1);
    chk(out_data == 32'hA5A5_0001, "R4 read of 0x10 returned", out_data, 32'hA5A5_0001);

    // R9: side-effect register read once per intended read
    begin
      int p0;
      p0 = pop_cnt;
      scan(1'b0, 7'h4, 32'h0, 40, 1'b0);
      scan(1'b0, 7'h4, 32'h0, 40, 1'b0);
      chk(out_data == 32'hF1F0_0000 + p0, "R9 first pop returned", out_data, 32'hF1F0_0000 + p0);
      scan(1'b0, 7'h0, 32'h0, 40, 1'b0);
      chk(out_data == 32'hF1F0_0001 + p0, "R9 second pop returned", out_data, 32'hF1F0_0001 + p0);
      chk(pop_cnt == p0 + 2, "R9 pop count", pop_cnt, p0 + 2);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule